// File: doc/BRIEF.md
# I2C Target Register Port with Pointer Stepping

This block is the control side of a small mixed-signal device. It listens on an I2C bus as a target and gives the bus host read and write access to a small file of 8-bit configuration registers. The registers are presented in parallel on the `reg_bus` output for use by the datapath. SCL and SDA come from an asynchronous bus, so both are oversampled by the fast system clock through synchronizers. START, repeated START and STOP are detected from the synchronized lines.

A write transfer first loads a pointer byte and then stores data bytes. The pointer's top bit selects whether the 7-bit register index steps by one after each data byte. A read transfer begins shifting data straight after the address acknowledge. It uses the pointer left by the most recent write, so a pointer-only write followed by a repeated START gives a random read. SDA is driven only through an open-drain enable.

The address/chip-select pin is shared. If a falling edge is ever seen on it after reset, the port hands over to SPI for good and I2C decoding stops.

Top module: `ctl_i2c_target`

## Requirements
- R1: SCL and SDA pass through two-flop synchronizers. A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START, repeated or not, always restarts address reception, whatever transfer is in progress.
- R2: The target answers the 7-bit address {1,0,0,1,0,`strap_a1`,`strap_a0_cs`}, sent MSB first. The eighth bit of that byte selects the direction: 0 is a write and 1 is a read. On a match the target acknowledges by pulling SDA low for the ninth clock.
- R3: In a write transfer, the first byte after the address acknowledge is the pointer byte. Every later byte is stored in the register that the pointer selects, and each byte is acknowledged. Register k appears on `reg_bus[8k+7:8k]`.
- R4: Bit 7 of the pointer byte is the step flag. Bits 6:0 of the pointer byte are the register index.
- R5: When the step flag is 1, the index increases by one after every data byte written, and after every read byte that the host acknowledges.
- R6: When the step flag is 0, the index stays the same across consecutive data bytes. Repeated writes overwrite the same register, and repeated reads return the same register.
- R7: In a read transfer, the target shifts out the register at the current index MSB first, starting straight after its address acknowledge. The index is the one left by the most recent write transfer.
- R8: Only indices 0 to 7 exist. Writes to indices 8 to 0x7F change no register, and reads from them return 0x00. The index wraps from 0x7F to 0x00 when it steps.
- R9: On an address mismatch, the target gives no acknowledge and never drives SDA. It ignores all bus traffic until the next START, including bytes that look like its own address.
- R10: A host NACK after a read byte ends the read, and SDA stays released. The index does not advance past the byte that was NACKed, so the next read returns that byte again.
- R11: `sda_oe` = 1 pulls SDA low. `sda_oe` becomes 1 only after a synchronized SCL falling edge, never while synchronized SCL is high. Registers likewise change only while synchronized SCL is low.
- R12: A falling edge on `strap_a0_cs` after reset sets `spi_mode` to 1 until the next reset. From then on the target never drives SDA and acknowledges no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_a1 | input | 1 | Address strap, bit 1 of the 7-bit address |
| strap_a0_cs | input | 1 | Address strap bit 0; a falling edge selects SPI |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| spi_mode | output | 1 | Sticky flag: port handed over to SPI |
| reg_bus | output | NREG*8 | All registers in parallel, register k at bits 8k+7:8k |

## Verification
Some properties are checked by the assertions on every cycle. Once SPI mode is set it never clears, and SDA is never driven while in it. The SDA drive is only ever switched on while synchronized SCL is low, and register contents only change while synchronized SCL is low.

Other behaviours need whole bus transfers, so only the bench scenarios can show them. These are the address match and mismatch, the pointer stepping and its wrap, unimplemented indices, and random reads through a repeated START. The bench also shows that a NACK holds the pointer, and it checks these results against a behavioural register and pointer model.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

  // Fixed upper part of the target address, sent first on the bus
  localparam logic [4:0] ADDR_FIXED = 5'b10010;
  // Width of the register index carried in the pointer byte
  localparam int IDX_W = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;

endpackage

// File: rtl/ctl_i2c_sync.sv
module ctl_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  input  logic a1_i,
  input  logic a0_i,
  output logic scl_s,
  output logic sda_s,
  output logic a1_s,
  output logic a0_s,
  output logic start_p,
  output logic stop_p,
  output logic cs_fall,
  output logic spi_mode
);

  logic [STAGES-1:0] scl_ff, sda_ff, a1_ff, a0_ff;
  logic scl_q, sda_q, a0_q;

  // Bus lines idle high; straps start low so a strap tied high never
  // looks like a falling edge when it first propagates.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      a1_ff  <= '0;
      a0_ff  <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      a0_q   <= 1'b0;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      a1_ff  <= {a1_ff[STAGES-2:0], a1_i};
      a0_ff  <= {a0_ff[STAGES-2:0], a0_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
      a0_q   <= a0_s;
    end
  end

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];
  assign a1_s  = a1_ff[STAGES-1];
  assign a0_s  = a0_ff[STAGES-1];

  // Data edges only count while the clock has been high on both samples
  assign start_p = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_p  = scl_s & scl_q & ~sda_q & sda_s;
  assign cs_fall = a0_q & ~a0_s;

  always_ff @(posedge clk) begin
    if (rst)          spi_mode <= 1'b0;
    else if (cs_fall) spi_mode <= 1'b1;
  end

endmodule

// File: rtl/ctl_i2c_regfile.sv
module ctl_i2c_regfile #(
  parameter int NREG  = 8,
  parameter int IDX_W = 7,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic [NREG*DW-1:0] reg_bus
);

  localparam int LAW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) mem[k] <= '0;
    end else if (wr_en && (int'(wr_idx) < NREG)) begin
      mem[wr_idx[LAW-1:0]] <= wr_data;
    end
  end

  // Unimplemented indices read as zero
  always_comb begin
    if (int'(rd_idx) < NREG) rd_data = mem[rd_idx[LAW-1:0]];
    else                     rd_data = '0;
  end

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_bus
      assign reg_bus[g*DW +: DW] = mem[g];
    end
  endgenerate

endmodule

// File: rtl/ctl_i2c_engine.sv
module ctl_i2c_engine
  import ctl_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              a1_s,
  input  logic              a0_s,
  input  logic              start_p,
  input  logic              stop_p,
  input  logic              halt,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [BYTE_W-1:0] rd_data
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  tgt_state_e        st;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [IDX_W-1:0]  idx;
  logic              step;
  logic              is_read;
  logic              host_ack;
  logic              scl_d;
  logic              scl_rise, scl_fall;

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;

  // Next byte to shift out: after a host ACK with stepping on, look ahead
  always_comb begin
    if (st == ST_RACK && step) rd_idx = idx + IDX_W'(1);
    else                       rd_idx = idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      idx      <= '0;
      step     <= 1'b0;
      is_read  <= 1'b0;
      host_ack <= 1'b0;
      scl_d    <= 1'b1;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      scl_d <= scl_s;
      wr_en <= 1'b0;
      if (halt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_p) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_p) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise && cnt != FULL) begin
              rx_sh <= {rx_sh[BYTE_W-2:0], sda_s};
              cnt   <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (st == ST_ADDR) begin
                if (rx_sh[7:1] == {ADDR_FIXED, a1_s, a0_s}) begin
                  is_read <= rx_sh[0];
                  sda_oe  <= 1'b1;
                  st      <= ST_ADDR_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_PTR) begin
                step   <= rx_sh[7];
                idx    <= rx_sh[IDX_W-1:0];
                sda_oe <= 1'b1;
                st     <= ST_PTR_ACK;
              end else begin
                wr_en   <= 1'b1;
                wr_idx  <= idx;
                wr_data <= rx_sh;
                if (step) idx <= idx + IDX_W'(1);
                sda_oe  <= 1'b1;
                st      <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (is_read) begin
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                cnt    <= '0;
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= ST_RACK;
              end else begin
                sda_oe <= ~tx_sh[BYTE_W-2];
                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                cnt    <= cnt + CNT_W'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (host_ack) begin
                idx    <= rd_idx;
                tx_sh  <= rd_data;
                sda_oe <= ~rd_data[BYTE_W-1];
                cnt    <= '0;
                st     <= ST_RDATA;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ctl_i2c_target.sv
module ctl_i2c_target
  import ctl_i2c_pkg::*;
#(
  parameter int NREG        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               strap_a1,
  input  logic               strap_a0_cs,
  output logic               sda_oe,
  output logic               spi_mode,
  output logic [NREG*8-1:0]  reg_bus
);

  logic scl_s, sda_s, a1_s, a0_s;
  logic start_p, stop_p, cs_fall;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [BYTE_W-1:0] wr_data, rd_data;

  ctl_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .a1_i     (strap_a1),
    .a0_i     (strap_a0_cs),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .a1_s     (a1_s),
    .a0_s     (a0_s),
    .start_p  (start_p),
    .stop_p   (stop_p),
    .cs_fall  (cs_fall),
    .spi_mode (spi_mode)
  );

  ctl_i2c_engine u_eng (
    .clk     (clk),
    .rst     (rst),
    .scl_s   (scl_s),
    .sda_s   (sda_s),
    .a1_s    (a1_s),
    .a0_s    (a0_s),
    .start_p (start_p),
    .stop_p  (stop_p),
    .halt    (spi_mode | cs_fall),
    .sda_oe  (sda_oe),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  ctl_i2c_regfile #(.NREG(NREG), .IDX_W(IDX_W), .DW(BYTE_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .reg_bus (reg_bus)
  );

endmodule

// File: rtl/ctl_i2c_target_chk.sv
module ctl_i2c_target_chk #(
  parameter int BUS_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_oe,
  input logic             spi_mode,
  input logic             scl_s,
  input logic [BUS_W-1:0] reg_bus
);

  // R12: hand-over to SPI never reverts
  a_r12_spi_sticky: assert property (@(posedge clk) disable iff (rst)
    spi_mode |=> spi_mode);

  // R12: no SDA drive while in SPI mode
  a_r12_spi_silent: assert property (@(posedge clk) disable iff (rst)
    spi_mode |-> !sda_oe);

  // R11: the drive turns on only after SCL has gone low
  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R11 / R3: register contents move only during SCL low
  a_r3_write_scl_low: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_bus) |-> !scl_s);

endmodule

bind ctl_i2c_target ctl_i2c_target_chk #(.BUS_W(NREG*8)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sda_oe   (sda_oe),
  .spi_mode (spi_mode),
  .scl_s    (scl_s),
  .reg_bus  (reg_bus)
);

// File: tb/sim_ctl_i2c_target.sv
`timescale 1ns/1ps
module sim_ctl_i2c_target;

  localparam int NREG = 8;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic a1 = 1'b0;
  logic a0 = 1'b1;
  logic sda_oe, spi_mode;
  logic [NREG*8-1:0] reg_bus;
  logic sda_line;

  int checks = 0;
  int failures = 0;
  bit quiet = 1'b0;
  bit nodrv = 1'b0;
  logic prev_oe = 1'b0;

  // Behavioural reference: register contents and pointer
  logic [7:0] mdl [NREG];
  int  m_idx = 0;
  bit  m_step = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  ctl_i2c_target #(.NREG(NREG)) u0 (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .strap_a1    (a1),
    .strap_a0_cs (a0),
    .sda_oe      (sda_oe),
    .spi_mode    (spi_mode),
    .reg_bus     (reg_bus)
  );

  function automatic logic [NREG*8-1:0] mdl_bus();
    logic [NREG*8-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*8 +: 8] = mdl[k];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model outside write bytes
  always @(negedge clk) begin
    if (!rst) begin
      if (quiet) chk(reg_bus === mdl_bus(), "R3 reg_bus vs model", reg_bus, mdl_bus());
      if (sda_oe && !prev_oe) chk(scl_m == 1'b0, "R11 drive began with SCL high", scl_m, 0);
      if (nodrv) chk(sda_oe == 1'b0, "R9/R12 SDA driven when silent", sda_oe, 0);
      prev_oe <= sda_oe;
    end
  end

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q();
      scl_m = 1'b1; wait_q(); wait_q();
      scl_m = 1'b0; wait_q();
    end
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    ack = ~sda_line; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic recv_byte(input bit do_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q();
      scl_m = 1'b1; wait_q();
      b[i] = sda_line; wait_q();
      scl_m = 1'b0; wait_q();
    end
    sda_m = do_ack ? 1'b0 : 1'b1; wait_q();
    scl_m = 1'b1; wait_q(); wait_q();
    scl_m = 1'b0; wait_q();
    sda_m = 1'b1;
  endtask

  // Write one data byte and apply it to the model
  task automatic wr_data(input logic [7:0] b, input string tag);
    bit ack;
    quiet = 1'b0;
    send_byte(b, ack);
    chk(ack, tag, ack, 1);
    if (m_idx < NREG) mdl[m_idx] = b;
    if (m_step) m_idx = (m_idx + 1) % 128;
    quiet = 1'b1;
  endtask

  task automatic wr_ptr(input logic [7:0] p, input string tag);
    bit ack;
    send_byte(p, ack);
    chk(ack, tag, ack, 1);
    m_step = p[7];
    m_idx = int'(p[6:0]);
  endtask

  // Read one byte and compare against the model pointer
  task automatic rd_data(input bit do_ack, input string tag);
    logic [7:0] got, exp;
    exp = (m_idx < NREG) ? mdl[m_idx] : 8'h00;
    recv_byte(do_ack, got);
    chk(got === exp, tag, got, exp);
    if (do_ack && m_step) m_idx = (m_idx + 1) % 128;
  endtask

  task automatic addr(input logic [7:0] b, input bit exp_ack, input string tag);
    bit ack;
    send_byte(b, ack);
    chk(ack == exp_ack, tag, ack, exp_ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < NREG; k++) mdl[k] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    chk(sda_oe == 1'b0, "reset sda_oe", sda_oe, 0);
    chk(spi_mode == 1'b0, "R12 reset spi_mode", spi_mode, 0);
    chk(reg_bus == '0, "R3 reset registers", reg_bus, 0);
    quiet = 1'b1;

    // R2/R3/R5: stepping block write to indices 2..4
    bus_start();
    addr(8'h92, 1'b1, "R2 write address ack");
    wr_ptr(8'h82, "R4 pointer ack");
    wr_data(8'h11, "R3 data ack");
    wr_data(8'h22, "R5 data ack");
    wr_data(8'h33, "R5 data ack");
    bus_stop();
    chk(reg_bus[4*8 +: 8] == 8'h33, "R5 block write reached index 4", reg_bus[4*8 +: 8], 8'h33);

    // R6: no stepping, both bytes land in index 5
    bus_start();
    addr(8'h92, 1'b1, "R2 write address ack");
    wr_ptr(8'h05, "R4 pointer ack");
    wr_data(8'h44, "R6 data ack");
    wr_data(8'h55, "R6 data ack");
    bus_stop();
    chk(reg_bus[5*8 +: 8] == 8'h55, "R6 last byte kept", reg_bus[5*8 +: 8], 8'h55);
    chk(reg_bus[6*8 +: 8] == 8'h00, "R6 next index untouched", reg_bus[6*8 +: 8], 8'h00);

    // R1/R7: random read via repeated START, stepping, NACK on third
    bus_start();
    addr(8'h92, 1'b1, "R2 write address ack");
    wr_ptr(8'h82, "R4 pointer ack");
    bus_rstart();
    addr(8'h93, 1'b1, "R1 R2 read address ack after repeated START");
    rd_data(1'b1, "R7 random read index 2");
    rd_data(1'b1, "R5 read step index 3");
    rd_data(1'b0, "R5 read step index 4");
    bus_stop();

    // R10: pointer held at the NACKed byte
    bus_start();
    addr(8'h93, 1'b1, "R2 read address ack");
    rd_data(1'b0, "R10 NACKed byte read again");
    bus_stop();

    // R6: no-step reads repeat
    bus_start();
    addr(8'h92, 1'b1, "R2 write address ack");
    wr_ptr(8'h05, "R4 pointer ack");
    bus_rstart();
    addr(8'h93, 1'b1, "R2 read address ack");
    rd_data(1'b1, "R6 read index 5");
    rd_data(1'b0, "R6 read index 5 again");
    bus_stop();

    // R8: writes past the file ignored, wrap to index 0
    bus_start();
    addr(8'h92, 1'b1, "R2 write address ack");
    wr_ptr(8'hFF, "R4 pointer ack");
    wr_data(8'hAA, "R8 unimplemented write ack");
    wr_data(8'hBB, "R8 wrapped write ack");
    bus_stop();
    chk(reg_bus[7:0] == 8'hBB, "R8 wrap to index 0", reg_bus[7:0], 8'hBB);

    // R8: unimplemented read returns zero, then wraps
    bus_start();
    addr(8'h92, 1'b1, "R2 write address ack");
    wr_ptr(8'hFF, "R4 pointer ack");
    bus_rstart();
    addr(8'h93, 1'b1, "R2 read address ack");
    rd_data(1'b1, "R8 unimplemented read zero");
    rd_data(1'b0, "R8 read wrapped to index 0");
    bus_stop();

    // R9: wrong address, all traffic ignored until next START
    nodrv = 1'b1;
    bus_start();
    addr(8'h96, 1'b0, "R9 mismatched address no ack");
    addr(8'h92, 1'b0, "R9 own address inside ignored transfer");
    addr(8'h81, 1'b0, "R9 byte ignored");
    addr(8'h77, 1'b0, "R9 byte ignored");
    bus_stop();
    nodrv = 1'b0;
    chk(reg_bus === mdl_bus(), "R9 registers untouched", reg_bus, mdl_bus());

    // R12: falling strap hands the port to SPI
    a0 = 1'b0;
    repeat (6) @(negedge clk);
    chk(spi_mode == 1'b1, "R12 spi_mode set", spi_mode, 1);
    nodrv = 1'b1;
    bus_start();
    addr(8'h92, 1'b0, "R12 no ack in SPI mode");
    addr(8'h90, 1'b0, "R12 no ack for new strap address");
    bus_stop();
    nodrv = 1'b0;
    chk(spi_mode == 1'b1, "R12 spi_mode sticky", spi_mode, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule